// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block turns one read or write command into the run of column addresses that the burst touches in a graphics DRAM style memory. A command strobe carries a start column. The burst length comes from a three-bit mode field, and the ordering request comes from a one-bit mode flag. After a command is accepted, the block puts out one column address per clock, with a valid strobe and with markers on the first and last beats.

Each burst stays inside an aligned block of columns the size of the burst and wraps at the block edge. The two lowest bits of the start column are always treated as zero. A length-8 burst can therefore start only at the lower or the upper half of its block. Only sequential ordering exists. A request for interleaved ordering, or a reserved length code, gives an error pulse and starts no burst. A command that arrives while a burst still has beats to deliver is refused and reported on a separate pulse. A command that arrives on the last beat is accepted, so bursts can follow each other with no gap.

Top module: `burst_col_seq`

## Requirements
- R1: Mode code 3'b010 on `mode_bl` gives a 4-beat burst and 3'b011 gives an 8-beat burst. `beat_valid` goes high in the cycle after the command is accepted and stays high for exactly that many consecutive cycles.
- R2: In a 4-beat burst, bits [1:0] of the column run 0,1,2,3. Bits [1:0] of `cmd_col` have no effect.
- R3: In an 8-beat burst, bits [2:0] of the column run 0..7 when `cmd_col[2]`=0 and 4,5,6,7,0,1,2,3 when `cmd_col[2]`=1. Bits [1:0] of `cmd_col` have no effect.
- R4: The column bits above the burst block (bits [COL_W-1:2] for 4 beats, bits [COL_W-1:3] for 8 beats) equal those of `cmd_col` on every beat.
- R5: `beat_first` is high only on the first beat and `beat_last` only on the final beat of a burst.
- R6: Any `mode_bl` code other than 3'b010 and 3'b011 makes `cfg_err` pulse high for one cycle after the command, and no burst starts.
- R7: `mode_type`=1 (interleaved ordering requested) makes `cfg_err` pulse for one cycle after the command, and no burst starts.
- R8: A command while `beat_valid` is high and `beat_last` is low is refused. `cmd_refused` pulses in the next cycle, `cfg_err` stays low, and the running burst continues unchanged.
- R9: A command in the cycle that shows `beat_last` is accepted, and its first beat appears in the very next cycle.
- R10: The mode inputs are sampled only when a command is accepted. Changing them during a burst does not change that burst.
- R11: After reset, `beat_valid`, `beat_first`, `beat_last`, `cmd_refused` and `cfg_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_bl | input | 3 | Burst length code: 3'b010 = 4, 3'b011 = 8, others reserved |
| mode_type | input | 1 | Ordering request: 0 = sequential, 1 = interleaved (refused) |
| cmd_valid | input | 1 | Read or write command strobe |
| cmd_col | input | COL_W | Start column of the command |
| beat_valid | output | 1 | A column address is being presented |
| beat_col | output | COL_W | Column address of the current beat |
| beat_first | output | 1 | Current beat is the first of its burst |
| beat_last | output | 1 | Current beat is the last of its burst |
| cmd_refused | output | 1 | One-cycle pulse: previous command arrived during a burst |
| cfg_err | output | 1 | One-cycle pulse: previous command had an illegal mode setting |

## Verification
Two functions can fall in the same cycle: the last beat of a burst and the acceptance of the next command. A refusal can also coincide with a mode setting that is itself illegal. The bench issues a command exactly on the cycle that shows `beat_last` and expects the new burst's first beat in the next cycle with no refusal. It also issues commands with a legal and with a reserved length code in the middle of a burst and expects only `cmd_refused`, while the running burst keeps its computed addresses.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

    localparam logic [2:0] BL_CODE_FOUR  = 3'b010;
    localparam logic [2:0] BL_CODE_EIGHT = 3'b011;

    typedef enum logic {
        LEN_FOUR  = 1'b0,
        LEN_EIGHT = 1'b1
    } burst_len_e;

    // index of the final beat for a given length
    function automatic logic [2:0] final_idx(input burst_len_e len);
        return (len == LEN_EIGHT) ? 3'd7 : 3'd3;
    endfunction

endpackage

// File: rtl/bcs_mode_decode.sv
module bcs_mode_decode
    import bcs_pkg::*;
(
    input  logic [2:0]  mode_bl,
    input  logic        mode_type,
    output logic        legal,
    output burst_len_e  len
);

    always_comb begin
        legal = 1'b0;
        len   = LEN_FOUR;
        unique case (mode_bl)
            BL_CODE_FOUR: begin
                legal = ~mode_type;
                len   = LEN_FOUR;
            end
            BL_CODE_EIGHT: begin
                legal = ~mode_type;
                len   = LEN_EIGHT;
            end
            default: begin
                legal = 1'b0;
                len   = LEN_FOUR;
            end
        endcase
    end

endmodule

// File: rtl/bcs_cmd_gate.sv
module bcs_cmd_gate (
    input  logic cmd_valid,
    input  logic busy,
    input  logic legal,
    output logic accept,
    output logic refuse,
    output logic reject_cfg
);

    // a busy engine outranks a bad mode setting
    always_comb begin
        refuse     = cmd_valid & busy;
        reject_cfg = cmd_valid & ~busy & ~legal;
        accept     = cmd_valid & ~busy & legal;
    end

endmodule

// File: rtl/bcs_addr_gen.sv
module bcs_addr_gen
    import bcs_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic [COL_W-1:0] base,
    input  burst_len_e       len,
    input  logic [2:0]       idx,
    output logic [COL_W-1:0] col
);

    localparam int BLK_W = 3;

    logic [BLK_W-1:0] wrap_sum;

    // modulo-8 add; the length-4 case only keeps the low two bits
    assign wrap_sum = base[BLK_W-1:0] + idx;

    for (genvar b = 0; b < BLK_W; b++) begin : g_blk_bit
        if (b < 2) begin : g_always_wrap
            assign col[b] = wrap_sum[b];
        end else begin : g_len_sel
            assign col[b] = (len == LEN_EIGHT) ? wrap_sum[b] : base[b];
        end
    end

    assign col[COL_W-1:BLK_W] = base[COL_W-1:BLK_W];

endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
    import bcs_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       mode_bl,
    input  logic             mode_type,
    input  logic             cmd_valid,
    input  logic [COL_W-1:0] cmd_col,
    output logic             beat_valid,
    output logic [COL_W-1:0] beat_col,
    output logic             beat_first,
    output logic             beat_last,
    output logic             cmd_refused,
    output logic             cfg_err
);

    localparam logic [COL_W-1:0] LOW_CLR = ~(COL_W'(3));

    typedef struct packed {
        logic             active;
        logic [2:0]       idx;
        burst_len_e       len;
        logic [COL_W-1:0] base;
        logic             refused;
        logic             err;
    } seq_t;

    seq_t st_d, st_q;

    logic       legal;
    burst_len_e dec_len;
    logic       at_last;
    logic       busy;
    logic       accept;
    logic       refuse;
    logic       reject_cfg;

    bcs_mode_decode i_decode (
        .mode_bl   (mode_bl),
        .mode_type (mode_type),
        .legal     (legal),
        .len       (dec_len)
    );

    assign at_last = st_q.active && (st_q.idx == final_idx(st_q.len));
    assign busy    = st_q.active && !at_last;

    bcs_cmd_gate i_gate (
        .cmd_valid  (cmd_valid),
        .busy       (busy),
        .legal      (legal),
        .accept     (accept),
        .refuse     (refuse),
        .reject_cfg (reject_cfg)
    );

    bcs_addr_gen #(.COL_W(COL_W)) i_addr (
        .base (st_q.base),
        .len  (st_q.len),
        .idx  (st_q.idx),
        .col  (beat_col)
    );

    always_comb begin
        st_d         = st_q;
        st_d.refused = refuse;
        st_d.err     = reject_cfg;
        if (accept) begin
            st_d.active = 1'b1;
            st_d.idx    = 3'd0;
            st_d.len    = dec_len;
            st_d.base   = cmd_col & LOW_CLR;
        end else if (st_q.active) begin
            if (at_last) begin
                st_d.active = 1'b0;
                st_d.idx    = 3'd0;
            end else begin
                st_d.idx = st_q.idx + 3'd1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign beat_valid  = st_q.active;
    assign beat_first  = st_q.active && (st_q.idx == 3'd0);
    assign beat_last   = at_last;
    assign cmd_refused = st_q.refused;
    assign cfg_err     = st_q.err;

endmodule

// File: rtl/bcs_checker.sv
module bcs_checker #(
    parameter int COL_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       mode_bl,
    input logic             mode_type,
    input logic             cmd_valid,
    input logic             beat_valid,
    input logic [COL_W-1:0] beat_col,
    input logic             beat_first,
    input logic             beat_last,
    input logic             cmd_refused,
    input logic             cfg_err
);

    logic mode_ok;
    assign mode_ok = ((mode_bl == 3'b010) || (mode_bl == 3'b011)) && !mode_type;

    AST_MARKS_NEED_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_first || beat_last) |-> beat_valid); // R5

    AST_FIRST_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        beat_first |-> (beat_col[1:0] == 2'b00)); // R2

    AST_NO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && !beat_last) |=> (beat_valid && !beat_first)); // R1

    AST_UPPER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && !beat_last) |=> ((beat_col >> 3) == ($past(beat_col) >> 3))); // R4

    AST_REFUSE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && beat_valid && !beat_last) |=> (cmd_refused && !cfg_err)); // R8

    AST_BAD_MODE_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !mode_ok && !(beat_valid && !beat_last)) |=> (cfg_err && !beat_valid)); // R6

    AST_CHAIN_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && mode_ok && beat_last) |=> (beat_first && !cmd_refused)); // R9

    AST_PULSES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_refused, cfg_err})); // R8

endmodule

bind burst_col_seq bcs_checker #(.COL_W(COL_W)) i_bcs_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_bl     (mode_bl),
    .mode_type   (mode_type),
    .cmd_valid   (cmd_valid),
    .beat_valid  (beat_valid),
    .beat_col    (beat_col),
    .beat_first  (beat_first),
    .beat_last   (beat_last),
    .cmd_refused (cmd_refused),
    .cfg_err     (cfg_err)
);

// File: tb/test_burst_col_seq.sv
`timescale 1ns/1ps
module test_burst_col_seq;

    localparam int COL_W = 6;
    localparam int NCOL  = 1 << COL_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [2:0]       mode_bl = 3'b010;
    logic             mode_type = 1'b0;
    logic             cmd_valid = 1'b0;
    logic [COL_W-1:0] cmd_col = '0;
    logic             beat_valid;
    logic [COL_W-1:0] beat_col;
    logic             beat_first;
    logic             beat_last;
    logic             cmd_refused;
    logic             cfg_err;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    burst_col_seq #(.COL_W(COL_W)) i_burst_col_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_bl     (mode_bl),
        .mode_type   (mode_type),
        .cmd_valid   (cmd_valid),
        .cmd_col     (cmd_col),
        .beat_valid  (beat_valid),
        .beat_col    (beat_col),
        .beat_first  (beat_first),
        .beat_last   (beat_last),
        .cmd_refused (cmd_refused),
        .cfg_err     (cfg_err)
    );

    task automatic chk(input int act, input int exp, input string req, input string what);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_col(input int col, input bit len8, input int k);
        int m;
        int base;
        m    = len8 ? 7 : 3;
        base = col & ~3;
        return (col & ~m) | (((base & m) + k) & m);
    endfunction

    // all tasks start and end at a falling edge
    task automatic issue(input int col, input bit len8);
        mode_bl   = len8 ? 3'b011 : 3'b010;
        mode_type = 1'b0;
        cmd_col   = COL_W'(col);
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic check_beat(input int col, input bit len8, input int k);
        int n;
        n = len8 ? 8 : 4;
        chk(int'(beat_valid), 1, "R1", "beat_valid");
        chk(int'(beat_col), exp_col(col, len8, k), len8 ? "R3" : "R2", "beat_col");
        chk(int'(beat_col) >> (len8 ? 3 : 2), col >> (len8 ? 3 : 2), "R4", "upper bits");
        chk(int'(beat_first), (k == 0) ? 1 : 0, "R5", "beat_first");
        chk(int'(beat_last), (k == n - 1) ? 1 : 0, "R5", "beat_last");
    endtask

    task automatic run_from(input int col, input bit len8, input int k0);
        for (int k = k0; k < (len8 ? 8 : 4); k++) begin
            check_beat(col, len8, k);
            @(negedge clk);
        end
    endtask

    task automatic bad_mode(input logic [2:0] code, input logic typ, input string req);
        mode_bl   = code;
        mode_type = typ;
        cmd_col   = COL_W'(21);
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(int'(cfg_err), 1, req, "cfg_err pulse");
        chk(int'(beat_valid), 0, req, "no burst start");
        @(negedge clk);
        chk(int'(cfg_err), 0, req, "cfg_err cleared");
        chk(int'(beat_valid), 0, req, "still idle");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // r11_ reset state
        chk(int'(beat_valid), 0, "R11", "beat_valid in reset");
        chk(int'(beat_first | beat_last), 0, "R11", "markers in reset");
        chk(int'(cmd_refused | cfg_err), 0, "R11", "pulses in reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk(int'(beat_valid), 0, "R11", "idle after reset");

        // R1 R2 R3 R4 R5: every start column, both lengths
        for (int l = 0; l < 2; l++) begin
            for (int c = 0; c < NCOL; c++) begin
                issue(c, l[0]);
                run_from(c, l[0], 0);
                chk(int'(beat_valid), 0, "R1", "idle after burst");
            end
        end

        // R6 reserved length codes
        for (int code = 0; code < 8; code++) begin
            if (code != 2 && code != 3) bad_mode(3'(code), 1'b0, "R6");
        end

        // R7 interleave request with both lengths
        bad_mode(3'b011, 1'b1, "R7");
        bad_mode(3'b010, 1'b1, "R7");

        // R8 refusal mid-burst, legal mode then reserved mode
        issue(13, 1'b1);
        run_from(13, 1'b1, 0);
        issue(13, 1'b1);
        check_beat(13, 1'b1, 0);
        @(negedge clk);
        check_beat(13, 1'b1, 1);
        mode_bl = 3'b010; cmd_col = COL_W'(40); cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(int'(cmd_refused), 1, "R8", "refused pulse");
        chk(int'(cfg_err), 0, "R8", "no cfg_err on refusal");
        check_beat(13, 1'b1, 2);
        mode_bl = 3'b000; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(int'(cmd_refused), 1, "R8", "refused with reserved code");
        chk(int'(cfg_err), 0, "R8", "refusal outranks cfg error");
        run_from(13, 1'b1, 3);
        chk(int'(beat_valid), 0, "R8", "refused command never ran");

        // R9 command on last beat chains directly
        issue(22, 1'b0);
        for (int k = 0; k < 4; k++) begin
            check_beat(22, 1'b0, k);
            if (k == 3) begin
                mode_bl = 3'b011; cmd_col = COL_W'(45); cmd_valid = 1'b1;
            end
            @(negedge clk);
            cmd_valid = 1'b0;
        end
        chk(int'(cmd_refused), 0, "R9", "chained command not refused");
        chk(int'(beat_first), 1, "R9", "chained first beat");
        run_from(45, 1'b1, 0);
        chk(int'(beat_valid), 0, "R9", "idle after chain");

        // R10 mode changes during burst are ignored
        issue(30, 1'b1);
        check_beat(30, 1'b1, 0);
        @(negedge clk);
        mode_bl = 3'b010; mode_type = 1'b1;
        run_from(30, 1'b1, 1);
        chk(int'(beat_valid), 0, "R10", "burst kept eight beats");
        chk(int'(cfg_err), 0, "R10", "no error without command");
        mode_type = 1'b0;

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog act=0 exp=1");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule